// File: doc/BRIEF.md
# Carry-Save Adder-Accumulator

This block sums a stream of unsigned input words without letting a carry travel more than one bit position per clock. Each bit position of the accumulator keeps two flip-flops, a sum bit and a carry bit. A carry bit stored at position j has weight 2^(j+1). The accumulated total is therefore `sum_vec + (carry_vec << 1)`, taken modulo 2^ACC_W. Each position holds a digit from 0 to 3. Because no carry ripples inside a cycle, the logic in front of every flip-flop is one adder cell deep, whatever the width.

The lowest IN_W positions use full-adder cells. Each one combines the incoming data bit, its own sum bit and the carry registered one position below. The guard positions above them use increment-only half-adder cells. The accumulator is IN_W + ceil(log2(MAX_WORDS)) bits wide, so MAX_WORDS full-scale words fit without wrapping. When a plain binary total is needed, a resolve request adds the two vectors in a carry-lookahead adder built from 4-bit groups. The result is registered and marked by a one-cycle done pulse. The carry-save pair is also visible on the ports.

Top module: `csa_accum`

## Requirements
- R1: While rst_n is low, sum_vec, carry_vec, result and done are all zero.
- R2: A cycle with clr high leaves sum_vec and carry_vec all zero after the next rising edge.
- R3: When clr and in_valid are high in the same cycle, clear wins: the word is discarded and the total is zero.
- R4: A cycle with in_valid high and clr low raises the total (sum_vec + 2·carry_vec, mod 2^ACC_W) by the unsigned value of in_data at the next edge.
- R5: A cycle with in_valid and clr both low leaves the total unchanged, although individual carry bits may still move.
- R6: A carry advances exactly one position per clock. Starting from a total of 15 with IN_W=4 and adding 1 gives sum_vec=0x0E, carry_vec=0x01. After each later idle cycle m (1 to 3), carry_vec=1<<m and sum_vec has ones only above bit m within the low 4 bits. After the 4th idle cycle, sum_vec=0x10 and carry_vec=0.
- R7: ACC_W = IN_W + ceil(log2(MAX_WORDS)). Summing MAX_WORDS words of all ones resolves to the exact total.
- R8: A resolve_req in one cycle gives done=1 in the next cycle, with result equal to the total seen in the request cycle. done is 0 in any cycle that does not follow a request.
- R9: Resolving does not disturb accumulation. A word absorbed in the request cycle is excluded from that result and included in later totals.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Synchronous clear of the accumulator |
| in_valid | input | 1 | Adds in_data this cycle |
| in_data | input | IN_W | Unsigned input word |
| resolve_req | input | 1 | Requests a binary result of the current total |
| sum_vec | output | ACC_W | Stored sum bit per position |
| carry_vec | output | ACC_W | Stored carry bit per position (weight 2^(j+1)) |
| result | output | ACC_W | Resolved binary total |
| done | output | 1 | One-cycle flag that result was updated |

## Verification
The bench uses IN_W=4 and MAX_WORDS=8. It sweeps every ordered pair of words and checks each resolved total against integer addition. A full adder that dropped a carry, or that read the wrong neighbour's carry, would miss pairs that produce carries.

A single carry is walked across the boundary between the full-adder cells and the half-adder cells. A design that propagated more than one position per cycle, or lost the carry at the boundary, would show the wrong vectors on some cycle.

Clear together with a valid word checks that the word is thrown away. A resolve in the same cycle as a new word checks that the result holds the old total. Random streams with idle gaps, plus a full-scale run, catch a lookahead group carry wired to the wrong group and a guard width that is too small.

// File: rtl/csa_accum.sv
module csa_accum #(
  parameter int IN_W      = 8,
  parameter int MAX_WORDS = 16,
  localparam int ACC_W    = IN_W + $clog2(MAX_WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             in_valid,
  input  logic [IN_W-1:0]  in_data,
  input  logic             resolve_req,
  output logic [ACC_W-1:0] sum_vec,
  output logic [ACC_W-1:0] carry_vec,
  output logic [ACC_W-1:0] result,
  output logic             done
);
  localparam int NG = (ACC_W + 3) / 4;
  localparam int PW = NG * 4;

  logic [ACC_W-1:0] ns, cy, ns_n, cy_n, cin;

  assign cin = {cy[ACC_W-2:0], 1'b0};

  for (genvar j = 0; j < ACC_W; j++) begin : g_cell
    if (j < IN_W) begin : g_full
      logic d;
      assign d       = in_valid & in_data[j];
      assign ns_n[j] = d ^ ns[j] ^ cin[j];
      assign cy_n[j] = (d & ns[j]) | (cin[j] & (d ^ ns[j]));
    end else begin : g_half
      assign ns_n[j] = ns[j] ^ cin[j];
      assign cy_n[j] = ns[j] & cin[j];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ns <= '0;
      cy <= '0;
    end else if (clr) begin
      ns <= '0;
      cy <= '0;
    end else begin
      ns <= ns_n;
      cy <= cy_n;
    end
  end

  assign sum_vec   = ns;
  assign carry_vec = cy;

  logic [PW-1:0] op_a, op_b, tot;
  logic [NG:0]   cg;

  assign op_a  = PW'(ns);
  assign op_b  = PW'(cin);
  assign cg[0] = 1'b0;

  for (genvar k = 0; k < NG; k++) begin : g_grp
    logic [3:0] g, p, c;
    logic       gg, pg;
    assign g    = op_a[4*k +: 4] & op_b[4*k +: 4];
    assign p    = op_a[4*k +: 4] ^ op_b[4*k +: 4];
    assign c[0] = cg[k];
    assign c[1] = g[0] | (p[0] & cg[k]);
    assign c[2] = g[1] | (p[1] & g[0]) | (p[1] & p[0] & cg[k]);
    assign c[3] = g[2] | (p[2] & g[1]) | (p[2] & p[1] & g[0])
                | (p[2] & p[1] & p[0] & cg[k]);
    assign gg   = g[3] | (p[3] & g[2]) | (p[3] & p[2] & g[1])
                | (p[3] & p[2] & p[1] & g[0]);
    assign pg   = &p;
    assign cg[k+1]      = gg | (pg & cg[k]);
    assign tot[4*k +: 4] = p ^ c;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result <= '0;
      done   <= 1'b0;
    end else begin
      done <= resolve_req;
      if (resolve_req) result <= tot[ACC_W-1:0];
    end
  end
endmodule

// File: rtl/csa_accum_chk.sv
module csa_accum_chk #(
  parameter int IN_W  = 8,
  parameter int ACC_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clr,
  input logic             in_valid,
  input logic [IN_W-1:0]  in_data,
  input logic             resolve_req,
  input logic [ACC_W-1:0] sum_vec,
  input logic [ACC_W-1:0] carry_vec,
  input logic [ACC_W-1:0] result,
  input logic             done
);
  logic [ACC_W-1:0] val;
  assign val = sum_vec + {carry_vec[ACC_W-2:0], 1'b0};

  always_comb begin
    if (!rst_n) p_reset_zero_r1: assert (sum_vec == '0 && carry_vec == '0 && !done);
  end

  p_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (sum_vec == '0 && carry_vec == '0));

  p_clear_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && in_valid) |=> val == '0);

  p_absorb_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !clr) |=> val == ACC_W'($past(val) + ACC_W'($past(in_data))));

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && !clr) |=> val == $past(val));

  p_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    resolve_req |=> (done && result == $past(val)));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !resolve_req |=> !done);
endmodule

bind csa_accum csa_accum_chk #(.IN_W(IN_W), .ACC_W(ACC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr(clr), .in_valid(in_valid), .in_data(in_data),
  .resolve_req(resolve_req), .sum_vec(sum_vec), .carry_vec(carry_vec),
  .result(result), .done(done)
);

// File: tb/csa_accum_tb.sv
module csa_accum_tb;
  localparam int IN_W  = 4;
  localparam int MAXW  = 8;
  localparam int ACC_W = 7;
  localparam int MASK  = 127;

  logic clk = 1'b0, rst_n = 1'b0, clr = 1'b0, in_valid = 1'b0, resolve_req = 1'b0;
  logic [IN_W-1:0]  in_data = '0;
  logic [ACC_W-1:0] sum_vec, carry_vec, result;
  logic             done;

  int checks = 0, failures = 0, expv = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #4 clk = ~clk;

  csa_accum #(.IN_W(IN_W), .MAX_WORDS(MAXW)) u_dut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .in_valid(in_valid), .in_data(in_data),
    .resolve_req(resolve_req), .sum_vec(sum_vec), .carry_vec(carry_vec),
    .result(result), .done(done)
  );

  function automatic int total();
    return (int'(sum_vec) + 2 * int'(carry_vec)) & MASK;
  endfunction

  task automatic chk(input string tag, input int act, input int exp_v);
    checks++;
    if (act != exp_v) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp_v);
    end
  endtask

  task automatic rnd(output int r);
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    r = int'(lfsr);
  endtask

  task automatic cyc(input logic c, input logic v, input int d, input logic r);
    clr = c; in_valid = v; in_data = IN_W'(d); resolve_req = r;
    @(negedge clk);
    if (c) expv = 0;
    else if (v) expv = (expv + d) & MASK;
    chk("R4/R5 total", total(), expv);
  endtask

  task automatic resolve(input string tag);
    int snap;
    snap = expv;
    cyc(1'b0, 1'b0, 0, 1'b1);
    chk({tag, " R8 done"}, int'(done), 1);
    chk({tag, " result"}, int'(result), snap);
    cyc(1'b0, 1'b0, 0, 1'b0);
    chk("R8 done pulse", int'(done), 0);
  endtask

  initial begin
    #(8 * 200000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int r, n, w;
    repeat (3) @(negedge clk);
    chk("R1 sum", int'(sum_vec), 0);
    chk("R1 carry", int'(carry_vec), 0);
    chk("R1 result", int'(result), 0);
    chk("R1 done", int'(done), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R4 exhaustive pairs
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++) begin
        cyc(1'b1, 1'b0, 0, 1'b0);
        cyc(1'b0, 1'b1, a, 1'b0);
        cyc(1'b0, 1'b1, b, 1'b0);
        resolve("R4 pair");
      end

    // R2 clear after nonzero state
    cyc(1'b0, 1'b1, 9, 1'b0);
    cyc(1'b1, 1'b0, 0, 1'b0);
    chk("R2 sum", int'(sum_vec), 0);
    chk("R2 carry", int'(carry_vec), 0);

    // R3 clear with valid
    cyc(1'b0, 1'b1, 7, 1'b0);
    cyc(1'b1, 1'b1, 5, 1'b0);
    chk("R3 sum", int'(sum_vec), 0);
    chk("R3 carry", int'(carry_vec), 0);

    // R6 carry walk
    cyc(1'b0, 1'b1, 15, 1'b0);
    cyc(1'b0, 1'b1, 1, 1'b0);
    chk("R6 sum0", int'(sum_vec), 'h0E);
    chk("R6 carry0", int'(carry_vec), 'h01);
    for (int m = 1; m <= 3; m++) begin
      cyc(1'b0, 1'b0, 0, 1'b0);
      chk("R6 carry", int'(carry_vec), 1 << m);
      chk("R6 sum", int'(sum_vec), 'hF & ~((2 << m) - 1));
    end
    cyc(1'b0, 1'b0, 0, 1'b0);
    chk("R6 sum4", int'(sum_vec), 'h10);
    chk("R6 carry4", int'(carry_vec), 0);
    // R5 hold over idle cycles
    repeat (4) cyc(1'b0, 1'b0, 0, 1'b0);
    chk("R5 held", total(), 16);

    // R7 full scale
    cyc(1'b1, 1'b0, 0, 1'b0);
    repeat (MAXW) cyc(1'b0, 1'b1, 15, 1'b0);
    resolve("R7 full scale");
    chk("R7 value", expv, 120);

    // R9 resolve with a word in the same cycle
    cyc(1'b1, 1'b0, 0, 1'b0);
    cyc(1'b0, 1'b1, 6, 1'b0);
    cyc(1'b0, 1'b1, 11, 1'b1);
    chk("R9 done", int'(done), 1);
    chk("R9 old total", int'(result), 6);
    resolve("R9 later total");

    // random streams with gaps
    for (int s = 0; s < 60; s++) begin
      cyc(1'b1, 1'b0, 0, 1'b0);
      rnd(r);
      n = 1 + (r % MAXW);
      for (int k = 0; k < n; k++) begin
        rnd(r);
        w = r & 15;
        cyc(1'b0, 1'b1, w, 1'b0);
        rnd(r);
        if (r[0]) cyc(1'b0, 1'b0, 0, 1'b0);
      end
      resolve("R4 stream");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule